// File: doc/BRIEF.md
# Two-Phase One-Hot Word Rotator

This block rotates a 32-bit word to the right by a binary amount from 0 to 31. The rotation is done in a crossbar field. Each output bit is the OR of all input bits, each gated by one select line. Select line k joins input bit (j+k) mod 32 to output bit j, for every j. Exactly one select line is driven at a time, so exactly one input bit reaches each output bit.

The select lines come from a clocked decoder that runs in two phases of the clock. While the clock is high (evaluate), the decoder drives the one line picked by the registered amount. The complementary rail carries the inverse of that line set, so the crossbar enables a path only when the true line is high and the complementary line is low. While the clock is low (precharge), every true line is forced low and every complementary line is forced high, so no crossbar path is enabled.

The word and the amount are captured on the rising clock edge, which starts evaluation, so control-to-output timing is counted from that edge. A hold register loads the evaluated word on the falling edge, and the output shows that word for the whole precharge phase. The output value therefore changes only once per clock period.

Top module: `rot_crossbar_unit`

## Requirements
- R1: While the clock is high, data_out[j] equals the captured word's bit (j+k) mod 32 for every j, where k is the captured amount (circular right rotation). A set bit 0 rotated by 1 lands in bit 31.
- R2: shift_amt is a plain unsigned binary count. Every value from 0 to 31 gives its own rotation, and a value of 0 passes the word through unchanged.
- R3: shift_amt and data_in are sampled only on the rising clock edge. A change at any other time does not alter data_out until the next rising edge.
- R4: While the clock is high, sel_line has exactly one bit set, and that bit's index equals the captured amount.
- R5: While the clock is low, sel_line is all zeros.
- R6: While the clock is low, data_out holds the word that was present during the preceding high phase.
- R7: sel_line_n is the bitwise inverse of sel_line while the clock is high, and all ones while the clock is low. A bit of sel_line and the same bit of sel_line_n are never both 1.
- R8: While rst_n is low, the captured amount, the captured word and the held word are all zero, so data_out reads zero in both phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. High is the evaluate phase, low is the precharge phase |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_amt | input | 5 | Rotate-right amount, binary, sampled at the rising edge |
| data_in | input | 32 | Word to rotate, sampled at the rising edge |
| data_out | output | 32 | Rotated word, driven live in evaluate and held in precharge |
| sel_line | output | 32 | One-hot select lines after phase gating (true rail) |
| sel_line_n | output | 32 | Complementary select lines after phase gating |

## Verification
The assertions assume that shift_amt and data_in settle away from the rising edge. They also assume that every value is sampled either fully before or fully after an edge's updates. That is why the select checks are written so that they hold for both the pre-edge and the post-edge view of each edge. The bench changes inputs only a few nanoseconds after an edge, inside the phase it means to exercise, and reads outputs mid-phase. The deliberate mid-phase changes used for R3 follow the same timing.

// File: rtl/rot_pkg.sv
package rot_pkg;

    localparam int ROT_WIDTH_DEFAULT = 32;

    typedef enum logic {
        PH_PRECHARGE = 1'b0,
        PH_EVALUATE  = 1'b1
    } phase_e;

endpackage

// File: rtl/rot_input_stage.sv
module rot_input_stage #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [AMT_W-1:0] amt_o,
    output logic [WIDTH-1:0] word_o
);

    typedef struct packed {
        logic [AMT_W-1:0] amt;
        logic [WIDTH-1:0] word;
    } stage_t;

    stage_t stage_d;
    stage_t stage_q;

    // Next state: capture both operands each rising edge (start of evaluate)
    always_comb begin
        stage_d      = stage_q;
        stage_d.amt  = amt_i;
        stage_d.word = word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign amt_o  = stage_q.amt;
    assign word_o = stage_q.word;

endmodule

// File: rtl/rot_phase_decoder.sv
module rot_phase_decoder #(
    parameter int WIDTH     = 32,
    parameter int AMT_W     = $clog2(WIDTH),
    parameter bit DUAL_RAIL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AMT_W-1:0] amt_i,
    output logic [WIDTH-1:0] raw_o,
    output logic [WIDTH-1:0] sel_o,
    output logic [WIDTH-1:0] sel_n_o,
    output logic [WIDTH-1:0] en_o
);
    import rot_pkg::*;

    phase_e phase;
    assign phase = clk ? PH_EVALUATE : PH_PRECHARGE;

    // Binary to one-hot: one comparator per line
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        assign raw_o[i] = (amt_i == AMT_W'(i));
    end

    // Phase qualification of both rails
    always_comb begin
        if (phase == PH_EVALUATE) begin
            sel_o   = raw_o;
            sel_n_o = ~raw_o;
        end else begin
            sel_o   = '0;
            sel_n_o = '1;
        end
    end

    // Path enable seen by the crossbar
    if (DUAL_RAIL) begin : g_dual
        assign en_o = sel_o & ~sel_n_o;
    end else begin : g_single
        assign en_o = sel_o;
    end

    // Gated true rail never carries more than one line
    p_sel_onehot0_r4: assert property (@(negedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    // Gated true rail is either fully blanked or equal to the raw decode
    p_sel_blank_or_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == '0) || (sel_o == raw_o));

    // Rails never both active on one line
    p_rails_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o & sel_n_o) == '0);

    // Complement rail has at most one line low
    p_comp_count_r7: assert property (@(negedge clk) disable iff (!rst_n)
        $countones(sel_n_o) >= WIDTH - 1);

endmodule

// File: rtl/rot_crossbar.sv
module rot_crossbar #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] en_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o
);

    // Output bit j collects input bit (j+i) mod WIDTH through enable line i
    for (genvar j = 0; j < WIDTH; j++) begin : g_out
        logic [WIDTH-1:0] tap;
        for (genvar i = 0; i < WIDTH; i++) begin : g_tap
            assign tap[i] = en_i[i] & data_i[(j + i) % WIDTH];
        end
        assign data_o[j] = |tap;
    end

endmodule

// File: rtl/rot_crossbar_unit.sv
module rot_crossbar_unit #(
    parameter int WIDTH     = rot_pkg::ROT_WIDTH_DEFAULT,
    parameter bit DUAL_RAIL = 1'b1,
    localparam int AMT_W    = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AMT_W-1:0] shift_amt,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] data_out,
    output logic [WIDTH-1:0] sel_line,
    output logic [WIDTH-1:0] sel_line_n
);

    logic [AMT_W-1:0] amt_q;
    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] raw_sel;
    logic [WIDTH-1:0] path_en;
    logic [WIDTH-1:0] live_word;
    logic [WIDTH-1:0] shadow_word;
    logic [WIDTH-1:0] hold_d;
    logic [WIDTH-1:0] hold_q;

    rot_input_stage #(
        .WIDTH (WIDTH),
        .AMT_W (AMT_W)
    ) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .amt_i  (shift_amt),
        .word_i (data_in),
        .amt_o  (amt_q),
        .word_o (word_q)
    );

    rot_phase_decoder #(
        .WIDTH     (WIDTH),
        .AMT_W     (AMT_W),
        .DUAL_RAIL (DUAL_RAIL)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .amt_i   (amt_q),
        .raw_o   (raw_sel),
        .sel_o   (sel_line),
        .sel_n_o (sel_line_n),
        .en_o    (path_en)
    );

    // Main field driven by phase-gated selects
    rot_crossbar #(
        .WIDTH (WIDTH)
    ) u_field (
        .en_i   (path_en),
        .data_i (word_q),
        .data_o (live_word)
    );

    // Ungated copy feeding the hold register, stable across the falling edge
    rot_crossbar #(
        .WIDTH (WIDTH)
    ) u_shadow (
        .en_i   (raw_sel),
        .data_i (word_q),
        .data_o (shadow_word)
    );

    always_comb begin
        hold_d = shadow_word;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign data_out = clk ? live_word : hold_q;

    // A rotation moves bits and never creates or drops one
    p_popcount_kept_r1: assert property (@(negedge clk) disable iff (!rst_n)
        $countones(data_out) == $countones(word_q));

endmodule

// File: tb/rot_crossbar_unit_bench.sv
module rot_crossbar_unit_bench;

    localparam int W  = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] drv_amt = '0;
    logic [W-1:0]  drv_data = '0;
    logic [W-1:0]  data_out;
    logic [W-1:0]  sel_line;
    logic [W-1:0]  sel_line_n;

    int total = 0;
    int bad = 0;
    bit chk_en = 1'b0;

    logic [AW-1:0] ref_amt = '0;
    logic [W-1:0]  ref_data = '0;

    rot_crossbar_unit u_rot_crossbar_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_amt  (drv_amt),
        .data_in    (drv_data),
        .data_out   (data_out),
        .sel_line   (sel_line),
        .sel_line_n (sel_line_n)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] rotr(logic [W-1:0] d, int k);
        logic [2*W-1:0] dd;
        dd = {d, d};
        return dd[k +: W];
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference: operands taken at the rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_amt  = '0;
            ref_data = '0;
        end else begin
            ref_amt  = drv_amt;
            ref_data = drv_data;
        end
    end

    // Evaluate phase compare
    always @(posedge clk) begin
        #5;
        if (chk_en && rst_n) begin
            check("R1 R2 evaluate word", data_out, rotr(ref_data, int'(ref_amt)));
            check("R4 one-hot select", sel_line, W'(1) << ref_amt);
            check("R7 complement evaluate", sel_line_n, ~(W'(1) << ref_amt));
        end
    end

    // Precharge phase compare
    always @(negedge clk) begin
        #5;
        if (chk_en && rst_n) begin
            check("R6 held word", data_out, rotr(ref_data, int'(ref_amt)));
            check("R5 select blanked", sel_line, '0);
            check("R7 complement blanked", sel_line_n, '1);
        end
    end

    task automatic drive(logic [AW-1:0] a, logic [W-1:0] d);
        @(negedge clk);
        #2;
        drv_amt  = a;
        drv_data = d;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #4_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        drv_data = 32'hA5A5_0F0F;
        drv_amt  = 5'd3;
        // R8: reset state in both phases
        #15;
        check("R8 reset evaluate", data_out, '0);
        #10;
        check("R8 reset precharge", data_out, '0);
        #2;
        rst_n  = 1'b1;
        chk_en = 1'b1;

        // R2: every amount with random data
        for (int k = 0; k < W; k++) begin
            drive(AW'(k), $urandom);
        end

        // Fixed patterns
        drive(5'd0, 32'hDEAD_BEEF);
        @(posedge clk); #6;
        check("R2 zero amount passes through", data_out, 32'hDEAD_BEEF);
        drive(5'd1, 32'h0000_0001);
        @(posedge clk); #6;
        check("R1 bit0 wraps to bit31", data_out, 32'h8000_0000);
        drive(5'd31, 32'h8000_0000);
        @(posedge clk); #6;
        check("R1 rotate by 31", data_out, 32'h0000_0001);
        drive(5'd17, 32'hFFFF_FFFF);
        drive(5'd8, 32'h5555_AAAA);
        @(posedge clk); #6;
        check("R1 alternating by 8", data_out, 32'hAA55_55AA);

        // R3: changes inside either phase leave the output alone
        drive(5'd4, 32'h1234_5678);
        @(posedge clk); #2;
        drv_amt  = 5'd9;
        drv_data = 32'hCAFE_F00D;
        #4;
        check("R3 change in evaluate ignored", data_out, 32'h8123_4567);
        @(negedge clk); #2;
        drv_amt  = 5'd20;
        drv_data = 32'h0F0F_0F0F;
        #4;
        check("R3 change in precharge ignored", data_out, 32'h8123_4567);
        @(posedge clk); #6;
        check("R3 new value after rising edge", data_out, rotr(32'h0F0F_0F0F, 20));

        // R8: reset in mid-run clears the held word
        drive(5'd5, 32'hFFFF_0000);
        @(posedge clk);
        @(negedge clk); #2;
        rst_n = 1'b0;
        #1;
        check("R8 mid-run reset", data_out, '0);
        @(negedge clk); #2;
        rst_n = 1'b1;
        drive(5'd12, $urandom);
        drive(5'd26, $urandom);

        repeat (3) @(posedge clk);
        #7;
        summary();
        $finish;
    end

endmodule